// File: doc/BRIEF.md
# Pipelined Vertical-Crosswise Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. The product is built recursively. At the bottom sits a 2x2 cell made of four AND gates and two half adders. Each larger size joins four half-size products: low-by-low, the two cross terms, and high-by-high. It joins them with parallel-prefix adders.

Every level of the recursion adds two register stages. The first stage holds the sum of the two cross terms next to the registered low and high sub-products. The second stage holds the merged product. The operands are captured in a register at the input. One new operand pair is accepted every clock and there is no stall path, which makes the block suitable as the multiply stage of a streaming multiply-accumulate datapath.

A valid flag travels beside the data through a shift register of the same depth. The total latency is LAT = 2*log2(N) clock edges, which is 6 for the default N = 8. The synchronous reset clears only the valid path. The data registers are not reset.

Top module: `vcm_top`

## Requirements
- R1: `prod` equals the unsigned product of the `a` and `b` values that were accepted, in 2N bits, with no truncation.
- R2: Define the rising edge that samples `in_valid` high as edge 1. `out_valid` is high, carrying that pair's product, right after edge LAT = 2*log2(N). Each accepted pair produces exactly one result, and results leave in the order the pairs were accepted.
- R3: A new pair may be presented on every clock. A fully back-to-back stream yields one correct product per clock.
- R4: While `rst` is high at a rising edge, the valid path is cleared. `out_valid` is low during reset, and pairs accepted before the reset never appear at the output.
- R5: A clock with `in_valid` low creates no result. `out_valid` is never high unless a pair is in flight.
- R6: Extreme operands give exact results. Zero times anything is 0. All-ones times all-ones is 2^(2N) - 2^(N+1) + 1. A single set bit times all-ones is a shifted all-ones pattern.
- R7: The 2x2 cell is exact for all 16 digit combinations. Its bit 0 is a0&b0. Its bit 1 is the XOR of the two cross products. Bits 2 and 3 are the half-adder sum and carry of a1&b1 with the cross carry. Operands whose low 2-bit digits take every combination multiply correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears the valid path |
| in_valid | input | 1 | Marks `a` and `b` as a pair to multiply |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| out_valid | output | 1 | Marks `prod` as a result |
| prod | output | 2N | Unsigned product |

## Verification
The hardest case to reach from the ports is a reset that arrives while products are still moving through the stages. The data registers keep stale values through the reset, so only the cleared valid path stops them from reappearing as results. The stimulus sends a burst of pairs and asserts reset before the first of them can emerge. It then clears the scoreboard and watches a full latency window for any stray `out_valid`. Back-to-back streams, streams with random gaps, and a sweep of every low-digit combination follow. Together they exercise every 2x2 cell pattern and the alignment of the cross terms while all stages are full.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
    // register stages inside a recursive multiplier of width w (w a power of two)
    function automatic int mul_stages(input int w);
        return 2 * $clog2(w) - 1;
    endfunction

    // total latency from the input register to the product, in clock edges
    function automatic int top_latency(input int w);
        return mul_stages(w) + 1;
    endfunction
endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2 (
    input  logic       clk,
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic pp_ll, pp_hl, pp_lh, pp_hh;
    logic x_sum, x_cry, h_sum, h_cry;

    always_comb begin
        pp_ll = a[0] & b[0];
        pp_hl = a[1] & b[0];
        pp_lh = a[0] & b[1];
        pp_hh = a[1] & b[1];
        x_sum = pp_hl ^ pp_lh;
        x_cry = pp_hl & pp_lh;
        h_sum = pp_hh ^ x_cry;
        h_cry = pp_hh & x_cry;
    end

    always_comb begin
        p_cell_exact_r7: assert ({h_cry, h_sum, x_sum, pp_ll} == ({2'b00, a} * {2'b00, b}));
    end

    always_ff @(posedge clk) begin
        p <= {h_cry, h_sum, x_sum, pp_ll};
    end
endmodule

// File: rtl/vcm_prefix_add.sv
module vcm_prefix_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   s
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] gg [0:LV];
    logic [W-1:0] pp [0:LV-1];

    assign gg[0] = x & y;
    assign pp[0] = x ^ y;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (((i >> l) & 1) == 1) begin : g_merge
                localparam int J = ((i >> l) << l) - 1;
                assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][J]);
                if (l + 1 < LV) begin : g_pm
                    assign pp[l+1][i] = pp[l][i] & pp[l][J];
                end
            end else begin : g_pass
                assign gg[l+1][i] = gg[l][i];
                if (l + 1 < LV) begin : g_pp
                    assign pp[l+1][i] = pp[l][i];
                end
            end
        end
    end

    assign s[0] = pp[0][0];
    for (genvar i = 1; i < W; i++) begin : g_sum
        assign s[i] = pp[0][i] ^ gg[LV][i-1];
    end
    assign s[W] = gg[LV][W-1];

    always_comb begin
        p_adder_sum_r1: assert (s == ({1'b0, x} + {1'b0, y}));
    end
endmodule

// File: rtl/vcm_mul.sv
module vcm_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    if (W == 2) begin : g_leaf
        vcm_cell2 u_cell (.clk(clk), .a(a), .b(b), .p(p));
    end else begin : g_node
        localparam int H  = W / 2;
        localparam int UW = 3 * H;
        localparam int PAD = UW - W - 1;

        logic [W-1:0] prod_ll, prod_lh, prod_hl, prod_hh;
        logic [W:0]   cross_sum;
        logic [W:0]   cross_q;
        logic [W-1:0] ll_q, hh_q;
        logic [UW:0]  merge_sum;
        logic [2*W-1:0] p_q;

        vcm_mul #(.W(H)) u_ll (.clk(clk), .a(a[H-1:0]), .b(b[H-1:0]), .p(prod_ll));
        vcm_mul #(.W(H)) u_lh (.clk(clk), .a(a[H-1:0]), .b(b[W-1:H]), .p(prod_lh));
        vcm_mul #(.W(H)) u_hl (.clk(clk), .a(a[W-1:H]), .b(b[H-1:0]), .p(prod_hl));
        vcm_mul #(.W(H)) u_hh (.clk(clk), .a(a[W-1:H]), .b(b[W-1:H]), .p(prod_hh));

        vcm_prefix_add #(.W(W)) u_cross (.x(prod_lh), .y(prod_hl), .s(cross_sum));

        always_ff @(posedge clk) begin
            cross_q <= cross_sum;
            ll_q    <= prod_ll;
            hh_q    <= prod_hh;
        end

        vcm_prefix_add #(.W(UW)) u_merge (
            .x({hh_q, ll_q[W-1:H]}),
            .y({{PAD{1'b0}}, cross_q}),
            .s(merge_sum)
        );

        always_comb begin
            p_merge_fits_r1: assert (merge_sum[UW] == 1'b0);
        end

        always_ff @(posedge clk) begin
            p_q <= {merge_sum[UW-1:0], ll_q[H-1:0]};
        end

        assign p = p_q;
    end
endmodule

// File: rtl/vcm_top.sv
module vcm_top #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic           out_valid,
    output logic [2*N-1:0] prod
);
    import vcm_pkg::*;

    localparam int LAT = top_latency(N);

    logic [N-1:0]   a_q, b_q;
    logic [LAT-1:0] vpipe;

    always_ff @(posedge clk) begin
        a_q <= a;
        b_q <= b;
    end

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    vcm_mul #(.W(N)) u_mul (.clk(clk), .a(a_q), .b(b_q), .p(prod));

    assign out_valid = vpipe[LAT-1];

    // in-flight tally kept apart from the valid shift register
    logic [7:0] inflight;
    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + 8'(in_valid) - 8'(out_valid);
    end

    p_inflight_match_r2: assert property (@(posedge clk) disable iff (rst)
        32'(inflight) == $countones(vpipe));

    p_no_phantom_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != 8'd0));

    p_reset_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/tb_vcm_top.sv
module tb_vcm_top;
    localparam int N = 8;
    localparam int LAT = 2 * $clog2(N);
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [2*N-1:0] val;
        int             due;
        string          req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N-1:0]   a = '0;
    logic [N-1:0]   b = '0;
    logic           out_valid;
    logic [2*N-1:0] prod;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb [$];

    vcm_top #(.N(N)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(out_valid), .prod(prod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic send(input logic [N-1:0] xa, input logic [N-1:0] xb, input string req);
        logic [2*N-1:0] ea, eb;
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        a = xa;
        b = xb;
        ea = {{N{1'b0}}, xa};
        eb = {{N{1'b0}}, xb};
        e.val = ea * eb;
        e.due = cyc + LAT;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a = N'($urandom);
            b = N'($urandom);
        end
    endtask

    // monitor: pops and compares at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 R4 stray result: out_valid=1 prod=%0h expected no output", prod);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (prod !== e.val) begin
                        errors++;
                        $display("FAIL %s R1 product: got %0h expected %0h", e.req, prod, e.val);
                    end
                    checks++;
                    if (cyc != e.due) begin
                        errors++;
                        $display("FAIL R2 timing: result at cycle %0d expected cycle %0d", cyc, e.due);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due < cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++; errors++;
                $display("FAIL R2 missing result: out_valid=0 at cycle %0d expected product %0h due %0d",
                         cyc, e.val, e.due);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [N-1:0] ones;
        ones = '1;

        // R4: out_valid low while held in reset
        rst = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R4 reset state: out_valid=%b expected 0", out_valid);
        end
        rst = 1'b0;
        idle(2);

        // R6: extreme operands
        send('0, '0, "R6");
        send(ones, ones, "R6");
        send(ones, N'(1), "R6");
        send(N'(1), ones, "R6");
        send('0, ones, "R6");
        send(N'(1) << (N-1), N'(1) << (N-1), "R6");
        send(N'(1) << (N-1), ones, "R6");
        idle(LAT + 2);

        // R3: back-to-back random stream
        for (int k = 0; k < 1000; k++) send(N'($urandom), N'($urandom), "R3");
        idle(LAT + 2);

        // R5: stream with random bubbles
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 3 == 0) idle(1 + ($urandom % 3));
            send(N'($urandom), N'($urandom), "R5");
        end
        idle(LAT + 2);

        // R7: every combination of the low two 2-bit digits, upper bits random
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [N-1:0] xa, xb;
                xa = N'($urandom);
                xb = N'($urandom);
                xa[3:0] = 4'(x);
                xb[3:0] = 4'(y);
                send(xa, xb, "R7");
            end
        end
        idle(LAT + 2);

        // R4: reset while products are in flight
        for (int k = 0; k < LAT - 2; k++) send(N'($urandom), N'($urandom), "R4");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        sb.delete();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R4 flushed pipe: out_valid=%b expected 0", out_valid);
        end
        rst = 1'b0;
        idle(LAT + 3);

        // R1: tail after reset, operands still multiply correctly
        for (int k = 0; k < 50; k++) send(N'($urandom), N'($urandom), "R1");
        idle(LAT + 3);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 undelivered results: got %0d pending expected 0", sb.size());
        end

        report();
        $finish;
    end
endmodule